// File: doc/BRIEF.md
# Supervisory Reset Sequencer with Manual Reset

This block generates the system reset for a chip from two requests. The first is a supply-low flag from an external voltage comparator, already synchronous to the block clock. The second is an active-low pushbutton input. Both requests have their own glitch filter. A request only counts once it has been present for a programmable number of consecutive clock cycles. The pushbutton line is also passed through a two-flop synchronizer ahead of its filter.

While either qualified request is present, reset is held. Once both are gone, a timeout counter runs for a programmable number of system clock cycles before reset is released. The default value gives 240 ms at 50 MHz. If a supply request qualifies during the countdown, the count clears and starts again only after that request is gone. At the end of the countdown the counter saturates, so it cannot wrap. A one-cycle completion strobe marks the release.

Parameters select the output polarity (active low, or its exact inverse) and the drive style. In open-drain style the level output is tied low, and an enable says when to pull the line down.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, reset is asserted and `rst_done_o` is 0. After `rst` falls with no request present, reset stays asserted for exactly TIMEOUT_CYC rising edges and is released on the last of them.
- R2: A supply-low flag held high for SUP_FILT_CYC edges asserts reset on edge SUP_FILT_CYC+1, and reset stays asserted while the qualified flag remains.
- R3: A supply-low pulse shorter than SUP_FILT_CYC edges neither asserts reset nor disturbs a countdown in progress.
- R4: A manual request (`mr_n_i` = 0) held for MR_FILT_CYC+2 edges asserts reset on edge MR_FILT_CYC+3. The extra cycles are two of synchronizer delay and one output register.
- R5: A manual low pulse shorter than MR_FILT_CYC edges has no effect on reset.
- R6: Once the last request is withdrawn at the pins, reset releases after a fixed count of edges. For supply that count is TIMEOUT_CYC+1, and for manual it is TIMEOUT_CYC+3.
- R7: A supply request that qualifies during the countdown clears it to zero and holds reset, even in the very cycle the countdown would have ended. The full timeout then runs again after the flag clears.
- R8: `rst_done_o` is 1 for exactly the one cycle in which reset is first seen released, and 0 at all other times.
- R9: With POLARITY = POL_HIGH, `sys_rst_o` is 1 when asserted. With POL_LOW it is 0 when asserted. The two settings give exact inverses.
- R10: With DRIVE = DRV_OPEN_DRAIN, `sys_rst_o` is constant 0 and `rst_oe_o` is 1 exactly while reset is asserted. With DRV_LEVEL, `rst_oe_o` is constant 1.
- R11: After release, the timeout counter saturates, and reset stays released without any strobe for as long as no request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset (power-up) |
| supply_low_i | input | 1 | Supply below threshold flag, already synchronous |
| mr_n_i | input | 1 | Manual reset pushbutton, active low, asynchronous |
| sys_rst_o | output | 1 | Reset level (polarity per POLARITY); 0 in open-drain style |
| rst_oe_o | output | 1 | Pull-down enable in open-drain style; 1 in level style |
| rst_done_o | output | 1 | One-cycle strobe when reset is released |

## Verification
Two events can land on the same clock edge: a supply dip qualifying, and the countdown reaching its terminal count. The bench times a dip so that its filter output becomes visible to the sequencer exactly on the edge where the release would otherwise happen. It then expects reset to stay asserted and no strobe to appear. It also expects the full timeout to be needed again, counted from the end of that dip. A second overlap holds both requests together and then withdraws the manual one first. The bench checks that the remaining supply request alone still holds reset.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum logic { POL_LOW = 1'b0, POL_HIGH = 1'b1 } rst_pol_e;
  typedef enum logic { DRV_LEVEL = 1'b0, DRV_OPEN_DRAIN = 1'b1 } rst_drv_e;
endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{IDLE_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_sup_filter.sv
// Qualifies a request only after it has been seen for LEN consecutive cycles;
// drops it on the first cycle the request is absent.
module rst_sup_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q;
  logic          qual_q;

  always_ff @(posedge clk) begin
    if (rst || !req_i) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (run_q == LAST) begin
      qual_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/rst_sup_timer.sv
// Holds reset while a request is present, then counts TIMEOUT quiet cycles.
module rst_sup_timer #(
  parameter int unsigned TIMEOUT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TERM = TW'(TIMEOUT);
  localparam logic [TW-1:0] PRE  = TW'(TIMEOUT - 1);

  logic [TW-1:0] cnt_q;
  logic          active_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (hold_i) begin
        cnt_q    <= '0;
        active_q <= 1'b1;
      end else if (cnt_q != TERM) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == PRE) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC  = 12_000_000,
  parameter int unsigned MR_FILT_CYC  = 8,
  parameter int unsigned SUP_FILT_CYC = 2000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter rst_pol_e    POLARITY     = POL_LOW,
  parameter rst_drv_e    DRIVE        = DRV_LEVEL
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low_i,
  input  logic mr_n_i,
  output logic sys_rst_o,
  output logic rst_oe_o,
  output logic rst_done_o
);
  logic mr_n_sync;
  logic mr_qual;
  logic sup_qual;
  logic cond;
  logic active;

  rst_sup_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst(rst), .d_i(mr_n_i), .q_o(mr_n_sync)
  );

  rst_sup_filter #(.LEN(MR_FILT_CYC)) u_mr_filt (
    .clk(clk), .rst(rst), .req_i(~mr_n_sync), .qual_o(mr_qual)
  );

  rst_sup_filter #(.LEN(SUP_FILT_CYC)) u_sup_filt (
    .clk(clk), .rst(rst), .req_i(supply_low_i), .qual_o(sup_qual)
  );

  assign cond = mr_qual | sup_qual;

  rst_sup_timer #(.TIMEOUT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .hold_i(cond), .active_o(active), .done_o(rst_done_o)
  );

  generate
    if (DRIVE == DRV_OPEN_DRAIN) begin : g_od
      assign sys_rst_o = 1'b0;
      assign rst_oe_o  = active;
    end else if (POLARITY == POL_HIGH) begin : g_hi
      assign sys_rst_o = active;
      assign rst_oe_o  = 1'b1;
    end else begin : g_lo
      assign sys_rst_o = ~active;
      assign rst_oe_o  = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk
  import rst_sup_pkg::*;
#(
  parameter rst_pol_e POLARITY = POL_LOW,
  parameter rst_drv_e DRIVE    = DRV_LEVEL
) (
  input logic clk,
  input logic rst,
  input logic cond_i,
  input logic sys_rst_o,
  input logic rst_oe_o,
  input logic rst_done_o
);
  logic asserted;

  always_comb begin
    if (DRIVE == DRV_OPEN_DRAIN)  asserted = rst_oe_o;
    else if (POLARITY == POL_HIGH) asserted = sys_rst_o;
    else                           asserted = ~sys_rst_o;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rst_done_o |=> !rst_done_o); // R8

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rst_done_o |-> (!asserted && $past(asserted))); // R8

  AST_CONDITION_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    cond_i |=> asserted); // R2

  AST_QUIET_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(asserted) |-> $past(!cond_i)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!asserted && !cond_i) |=> !asserted); // R11
endmodule

bind rst_supervisor rst_supervisor_chk #(.POLARITY(POLARITY), .DRIVE(DRIVE)) chk_i (
  .clk(clk), .rst(rst), .cond_i(cond), .sys_rst_o(sys_rst_o),
  .rst_oe_o(rst_oe_o), .rst_done_o(rst_done_o)
);

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;
  import rst_sup_pkg::*;

  localparam int unsigned T_CYC = 20;
  localparam int unsigned MF    = 4;
  localparam int unsigned SF    = 3;
  localparam int unsigned NROWS = 34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup = 1'b0;
  logic mrn = 1'b1;
  logic lo_rst, lo_oe, lo_done;
  logic hi_rst, hi_oe, hi_done;
  logic od_rst, od_oe, od_done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  rst_supervisor #(.TIMEOUT_CYC(T_CYC), .MR_FILT_CYC(MF), .SUP_FILT_CYC(SF),
    .POLARITY(POL_LOW), .DRIVE(DRV_LEVEL)) dut_i (
    .clk(clk), .rst(rst), .supply_low_i(sup), .mr_n_i(mrn),
    .sys_rst_o(lo_rst), .rst_oe_o(lo_oe), .rst_done_o(lo_done));

  rst_supervisor #(.TIMEOUT_CYC(T_CYC), .MR_FILT_CYC(MF), .SUP_FILT_CYC(SF),
    .POLARITY(POL_HIGH), .DRIVE(DRV_LEVEL)) dut_hi_i (
    .clk(clk), .rst(rst), .supply_low_i(sup), .mr_n_i(mrn),
    .sys_rst_o(hi_rst), .rst_oe_o(hi_oe), .rst_done_o(hi_done));

  rst_supervisor #(.TIMEOUT_CYC(T_CYC), .MR_FILT_CYC(MF), .SUP_FILT_CYC(SF),
    .POLARITY(POL_LOW), .DRIVE(DRV_OPEN_DRAIN)) dut_od_i (
    .clk(clk), .rst(rst), .supply_low_i(sup), .mr_n_i(mrn),
    .sys_rst_o(od_rst), .rst_oe_o(od_oe), .rst_done_o(od_done));

  // Row: {supply, mr_n, edges, expected asserted, expected done, requirement}
  localparam logic [15:0] TBL [NROWS] = '{
    {1'b1, 1'b1, 8'd2,   1'b0, 1'b0, 4'd3},  // R3 short dip ignored
    {1'b0, 1'b1, 8'd20,  1'b0, 1'b0, 4'd3},  // R3
    {1'b1, 1'b1, 8'd3,   1'b0, 1'b0, 4'd2},  // R2 not yet
    {1'b1, 1'b1, 8'd1,   1'b1, 1'b0, 4'd2},  // R2 asserts on edge SF+1
    {1'b0, 1'b1, 8'd19,  1'b1, 1'b0, 4'd6},  // R6
    {1'b0, 1'b1, 8'd1,   1'b1, 1'b0, 4'd6},  // R6
    {1'b0, 1'b1, 8'd1,   1'b0, 1'b1, 4'd6},  // R6 release at T+1, R8 strobe
    {1'b0, 1'b1, 8'd1,   1'b0, 1'b0, 4'd8},  // R8 one cycle only
    {1'b1, 1'b1, 8'd4,   1'b1, 1'b0, 4'd2},  // R2
    {1'b0, 1'b1, 8'd15,  1'b1, 1'b0, 4'd7},  // R7
    {1'b1, 1'b1, 8'd4,   1'b1, 1'b0, 4'd7},  // R7 restart
    {1'b0, 1'b1, 8'd20,  1'b1, 1'b0, 4'd7},  // R7 full timeout again
    {1'b0, 1'b1, 8'd1,   1'b0, 1'b1, 4'd7},  // R7
    {1'b1, 1'b1, 8'd4,   1'b1, 1'b0, 4'd2},  // R2
    {1'b0, 1'b1, 8'd10,  1'b1, 1'b0, 4'd3},  // R3
    {1'b1, 1'b1, 8'd2,   1'b1, 1'b0, 4'd3},  // R3 glitch mid countdown
    {1'b0, 1'b1, 8'd8,   1'b1, 1'b0, 4'd3},  // R3
    {1'b0, 1'b1, 8'd1,   1'b0, 1'b1, 4'd3},  // R3 countdown not restarted
    {1'b0, 1'b1, 8'd100, 1'b0, 1'b0, 4'd11}, // R11 saturated, no wrap
    {1'b0, 1'b0, 8'd3,   1'b0, 1'b0, 4'd5},  // R5 short press
    {1'b0, 1'b1, 8'd10,  1'b0, 1'b0, 4'd5},  // R5 ignored
    {1'b0, 1'b0, 8'd6,   1'b0, 1'b0, 4'd4},  // R4 not yet
    {1'b0, 1'b0, 8'd1,   1'b1, 1'b0, 4'd4},  // R4 asserts on edge MF+3
    {1'b0, 1'b0, 8'd30,  1'b1, 1'b0, 4'd4},  // R4 held
    {1'b0, 1'b1, 8'd22,  1'b1, 1'b0, 4'd6},  // R6
    {1'b0, 1'b1, 8'd1,   1'b0, 1'b1, 4'd6},  // R6 release at T+3
    {1'b1, 1'b0, 8'd10,  1'b1, 1'b0, 4'd2},  // R2 both requests
    {1'b1, 1'b1, 8'd10,  1'b1, 1'b0, 4'd2},  // R2 supply alone holds
    {1'b0, 1'b1, 8'd20,  1'b1, 1'b0, 4'd6},  // R6
    {1'b0, 1'b1, 8'd1,   1'b0, 1'b1, 4'd6},  // R6
    {1'b1, 1'b1, 8'd4,   1'b1, 1'b0, 4'd2},  // R2
    {1'b0, 1'b1, 8'd17,  1'b1, 1'b0, 4'd7},  // R7
    {1'b1, 1'b1, 8'd4,   1'b1, 1'b0, 4'd7},  // R7 dip lands on expiry edge
    {1'b0, 1'b1, 8'd21,  1'b0, 1'b1, 4'd7}   // R7 full timeout from dip end
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Checks every variant against one expected logical state.
  task automatic check_all(input string tag, input logic exp_a, input logic exp_d);
    check_bit({tag, " level"}, ~lo_rst, exp_a);
    check_bit({tag, " R8 done"}, lo_done, exp_d);
    check_bit({tag, " R9 high polarity"}, hi_rst, exp_a);
    check_bit({tag, " R9 level oe"}, hi_oe & lo_oe, 1'b1);
    check_bit({tag, " R10 od enable"}, od_oe, exp_a);
    check_bit({tag, " R10 od level"}, od_rst, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    step(4);
    check_all("R1 in reset", 1'b1, 1'b0);
    rst = 1'b0;
    step(19);
    check_all("R1 power-up hold", 1'b1, 1'b0);
    step(1);
    check_all("R1 power-up release", 1'b0, 1'b1);
    for (int i = 0; i < NROWS; i++) begin
      sup = TBL[i][15];
      mrn = TBL[i][14];
      step(int'(TBL[i][13:6]));
      check_all($sformatf("row%0d R%0d", i, TBL[i][3:0]), TBL[i][5], TBL[i][4]);
    end
    // Directed: reset mid countdown re-arms power-up hold (R1)
    sup = 1'b1;
    step(4);
    sup = 1'b0;
    step(5);
    rst = 1'b1;
    step(2);
    check_all("R1 re-reset", 1'b1, 1'b0);
    rst = 1'b0;
    step(20);
    check_all("R1 re-reset release", 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200us;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule